// File: doc/BRIEF.md
# Instruction Fetch Key Protection Checker

This block decides whether an instruction fetch may go ahead on a page that has already been translated. Software loads a 64-bit fetch-authority mask that holds one 2-bit mask for each of 32 protection keys. For each fetch request, the caller supplies three inputs: the second doubleword of the hashed page entry, the read/write/execute permission vector that the base page protection produced, and a flag that says whether the configured memory-management level supports key-based fetch control.

The block builds a 5-bit key from two separate fields of the page word and picks that key's mask. The key can only take away execute permission. The block then returns the merged permission vector and an execute-allowed flag. When the fetch is refused, it raises a fault with a cause word. One cause bit blames the base protection and another blames the key, and both can be set together. Every result is registered and appears exactly one cycle after its request.

Top module: `fetch_key_guard`

## Requirements
- R1: After reset the authority mask is all zero, so every key allows execution, and `resp_valid` is 0.
- R2: The key is `{pte_word[61:60], pte_word[11:9]}`, where `pte_word[61:60]` form the two most significant key bits.
- R3: The mask for key k occupies bits `[63-2k : 62-2k]` of the authority mask. If its low bit (bit `62-2k`) is 1, execute is removed. Its high bit (bit `63-2k`) has no effect on fetches.
- R4: The permission vector is encoded as bit 2 = read, bit 1 = write, bit 0 = execute. `perm_out[2:1]` always equals the requested `base_perm[2:1]`. `perm_out[0]` is `base_perm[0]` with the key result ANDed in.
- R5: When `key_check_en` is 0, the key is ignored and `perm_out` equals `base_perm`.
- R6: `resp_valid` is `req_valid` delayed by one cycle. In a cycle that follows no request, `perm_out`, `exec_ok`, `fault` and `fault_cause` are all zero.
- R7: `exec_ok` equals `perm_out[0]`. `fault` is 1 exactly when `resp_valid` is 1 and `exec_ok` is 0.
- R8: On a fault, bit 27 of `fault_cause` (value 0x08000000) is set when `base_perm[0]` was 0.
- R9: On a fault, bit 21 of `fault_cause` (value 0x00200000) is set when the key removed execute. Bits 27 and 21 may both be set. All other bits are zero, and the whole word is zero when `fault` is 0.
- R10: A mask write in the same cycle as a request affects only later requests. That request is checked against the previous mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Write strobe for the authority mask |
| mask_wdata | input | 64 | New authority mask value |
| req_valid | input | 1 | Fetch check request |
| pte_word | input | 64 | Second doubleword of the page entry |
| base_perm | input | 3 | Base permissions {read, write, execute} |
| key_check_en | input | 1 | Memory-management level supports key fetch control |
| resp_valid | output | 1 | Result valid, one cycle after request |
| perm_out | output | 3 | Merged permissions {read, write, execute} |
| exec_ok | output | 1 | Fetch may execute |
| fault | output | 1 | Instruction storage fault raised |
| fault_cause | output | 64 | Fault cause bits |

## Verification
The hardest case to reach from the ports is a mask write that lands in the same cycle as a request whose outcome the write would change. The bench drives both in one cycle, with a mask that turns that key's deny bit on. It expects the old allow result first and the deny result on the next request. It also writes a single low bit, and then a single high bit, into every key's slot. Each slot is probed with its own key and with its neighbour's key, so that a swapped or shifted lane shows up.

// File: rtl/fkg_pkg.sv
package fkg_pkg;
    localparam int NUM_KEYS   = 32;
    localparam int KEY_W      = $clog2(NUM_KEYS);
    localparam int LANE_W     = 2;
    localparam int MASK_W     = LANE_W * NUM_KEYS;
    localparam int WORD_W     = 64;
    localparam int PERM_W     = 3;
    localparam int PERM_X     = 0;
    localparam int KEY_HI_W   = 2;
    localparam int KEY_HI_LSB = 60;
    localparam int KEY_LO_W   = KEY_W - KEY_HI_W;
    localparam int KEY_LO_LSB = 9;
    localparam int CAUSE_BASE = 27;
    localparam int CAUSE_KEY  = 21;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              vld;
        logic [PERM_W-1:0] perm;
        logic              ok;
        logic              fault;
        logic [WORD_W-1:0] cause;
    } guard_state_t;
endpackage

// File: rtl/fkg_key_extract.sv
module fkg_key_extract
    import fkg_pkg::*;
(
    input  logic [WORD_W-1:0] pte,
    output logic [KEY_W-1:0]  key
);
    localparam int HI_TOP = KEY_HI_LSB + KEY_HI_W;
    localparam int LO_TOP = KEY_LO_LSB + KEY_LO_W;

    logic unused_pte_bits;

    always_comb begin
        key = {pte[KEY_HI_LSB +: KEY_HI_W], pte[KEY_LO_LSB +: KEY_LO_W]};
    end

    assign unused_pte_bits = ^{pte[WORD_W-1:HI_TOP], pte[KEY_HI_LSB-1:LO_TOP],
                               pte[KEY_LO_LSB-1:0]};
endmodule

// File: rtl/fkg_mask_lane.sv
module fkg_mask_lane
    import fkg_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic [KEY_W-1:0]  key,
    output logic [LANE_W-1:0] lane
);
    logic [LANE_W-1:0] lanes [NUM_KEYS];

    // Key 0 sits in the most significant lane, key NUM_KEYS-1 in the least.
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_lane
        assign lanes[g] = mask[MASK_W-1-LANE_W*g -: LANE_W];
    end

    always_comb begin
        lane = lanes[key];
    end
endmodule

// File: rtl/fkg_cause_enc.sv
module fkg_cause_enc
    import fkg_pkg::*;
(
    input  logic              fault,
    input  logic              base_no_x,
    input  logic              key_deny,
    output logic [WORD_W-1:0] cause
);
    always_comb begin
        cause = '0;
        if (fault) begin
            cause[CAUSE_BASE] = base_no_x;
            cause[CAUSE_KEY]  = key_deny;
        end
    end
endmodule

// File: rtl/fetch_key_guard.sv
module fetch_key_guard
    import fkg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] pte_word,
    input  logic [PERM_W-1:0] base_perm,
    input  logic              key_check_en,
    output logic              resp_valid,
    output logic [PERM_W-1:0] perm_out,
    output logic              exec_ok,
    output logic              fault,
    output logic [WORD_W-1:0] fault_cause
);
    guard_state_t d, q;

    logic [KEY_W-1:0]  key;
    logic [LANE_W-1:0] lane;
    logic              key_deny;
    logic [PERM_W-1:0] perm_n;
    logic              fault_n;
    logic [WORD_W-1:0] cause_n;
    logic              unused_lane_hi;

    fkg_key_extract u_key (
        .pte (pte_word),
        .key (key)
    );

    // Lookup uses the registered mask, so a same-cycle write is not seen.
    fkg_mask_lane u_lane (
        .mask (q.mask),
        .key  (key),
        .lane (lane)
    );

    always_comb begin
        key_deny       = key_check_en & lane[0];
        unused_lane_hi = lane[LANE_W-1];
        perm_n         = base_perm;
        perm_n[PERM_X] = base_perm[PERM_X] & ~key_deny;
        fault_n        = ~perm_n[PERM_X];
    end

    fkg_cause_enc u_cause (
        .fault     (fault_n),
        .base_no_x (~base_perm[PERM_X]),
        .key_deny  (key_deny),
        .cause     (cause_n)
    );

    always_comb begin
        d     = q;
        d.vld = req_valid;
        if (mask_we) begin
            d.mask = mask_wdata;
        end
        if (req_valid) begin
            d.perm  = perm_n;
            d.ok    = perm_n[PERM_X];
            d.fault = fault_n;
            d.cause = cause_n;
        end else begin
            d.perm  = '0;
            d.ok    = 1'b0;
            d.fault = 1'b0;
            d.cause = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign resp_valid  = q.vld;
    assign perm_out    = q.perm;
    assign exec_ok     = q.ok;
    assign fault       = q.fault;
    assign fault_cause = q.cause;
endmodule

// File: rtl/fetch_key_guard_chk.sv
module fetch_key_guard_chk
    import fkg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PERM_W-1:0] base_perm,
    input logic              key_check_en,
    input logic              resp_valid,
    input logic [PERM_W-1:0] perm_out,
    input logic              exec_ok,
    input logic              fault,
    input logic [WORD_W-1:0] fault_cause
);
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && perm_out == '0 && !exec_ok));
    p_rw_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> perm_out[2:1] == $past(base_perm[2:1]));
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !key_check_en) |=> perm_out == $past(base_perm));
    p_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault == (resp_valid && !exec_ok));
    p_ok_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_ok == perm_out[PERM_X]);
    p_base_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !base_perm[PERM_X]) |=> (fault && fault_cause[CAUSE_BASE]));
    p_clean_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> fault_cause == '0);
    p_cause_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($countones(fault_cause) >= 1 && $countones(fault_cause) <= 2));
endmodule

bind fetch_key_guard fetch_key_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .base_perm    (base_perm),
    .key_check_en (key_check_en),
    .resp_valid   (resp_valid),
    .perm_out     (perm_out),
    .exec_ok      (exec_ok),
    .fault        (fault),
    .fault_cause  (fault_cause)
);

// File: tb/fetch_key_guard_bench.sv
module fetch_key_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_we = 1'b0;
    logic [63:0] mask_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] pte_word = '0;
    logic [2:0]  base_perm = '0;
    logic        key_check_en = 1'b0;
    logic        resp_valid;
    logic [2:0]  perm_out;
    logic        exec_ok;
    logic        fault;
    logic [63:0] fault_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [63:0] shadow = '0;

    always #5 clk = ~clk;

    fetch_key_guard u_fetch_key_guard (
        .clk (clk), .rst_n (rst_n), .mask_we (mask_we), .mask_wdata (mask_wdata),
        .req_valid (req_valid), .pte_word (pte_word), .base_perm (base_perm),
        .key_check_en (key_check_en), .resp_valid (resp_valid), .perm_out (perm_out),
        .exec_ok (exec_ok), .fault (fault), .fault_cause (fault_cause)
    );

    task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Place key k into a page word with busy filler around the key fields.
    function automatic logic [63:0] make_pte(input int k, input logic [63:0] fill);
        logic [63:0] w;
        logic [4:0]  kk;
        kk = 5'(k);
        w = fill;
        w[61:60] = kk[4:3];
        w[11:9]  = kk[2:0];
        return w;
    endfunction

    function automatic logic [69:0] expect_of(input int k, input logic [2:0] bp,
                                               input logic en, input logic [63:0] m);
        logic       kd;
        logic [2:0] p;
        logic [63:0] c;
        kd = en & m[62-2*k];
        p  = {bp[2:1], bp[0] & ~kd};
        c  = '0;
        if (!p[0]) begin
            c[27] = ~bp[0];
            c[21] = kd;
        end
        return {1'b1, p, p[0], ~p[0], c};
    endfunction

    task automatic write_mask(input logic [63:0] v);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0;
        shadow = v;
    endtask

    task automatic probe(input string tag, input int k, input logic [2:0] bp,
                         input logic en, input logic [63:0] fill);
        logic [69:0] e;
        e = expect_of(k, bp, en, shadow);
        req_valid = 1'b1; pte_word = make_pte(k, fill); base_perm = bp; key_check_en = en;
        @(negedge clk);
        req_valid = 1'b0; pte_word = '0;
        check(tag, {resp_valid, perm_out, exec_ok, fault, fault_cause}, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {resp_valid, perm_out, exec_ok, fault, fault_cause}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 32; k += 7) probe("R1 all keys allow after reset", k, 3'b111, 1'b1, 64'h0);

        // R2/R3/R9: low-bit sweep, own key denies, neighbour allows
        for (int k = 0; k < 32; k++) begin
            write_mask(64'h1 << (62 - 2*k));
            probe("R3 R9 low bit denies own key", k, 3'b111, 1'b1, 64'hA5A5_5A5A_C3C3_3C3C);
            probe("R2 R3 neighbour key allowed", (k + 1) % 32, 3'b101, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        // R3: high-bit sweep has no effect
        for (int k = 0; k < 32; k++) begin
            write_mask(64'h1 << (63 - 2*k));
            probe("R3 high bit ignored", k, 3'b011, 1'b1, 64'h0123_4567_89AB_CDEF);
        end

        // Worked case: key 0x0A, bits [43:42] = 01
        write_mask(64'h0000_0400_0000_0000);
        probe("R9 key 10 denies, key cause only", 10, 3'b111, 1'b1, 64'h0);
        // R8: base lacks execute, key allows
        probe("R8 base cause only", 11, 3'b110, 1'b1, 64'h0);
        // R8 R9 together
        probe("R8 R9 both causes", 10, 3'b100, 1'b1, 64'h0);
        // R4: read/write pass-through on a denial
        probe("R4 rw pass on deny", 10, 3'b011, 1'b1, 64'h0);
        // R5: bypass
        probe("R5 bypass ignores key", 10, 3'b111, 1'b0, 64'h0);
        probe("R5 bypass base deny", 10, 3'b010, 1'b0, 64'h0);

        // R6: idle cycle after a request clears outputs
        @(negedge clk);
        check("R6 idle zero", {resp_valid, perm_out, exec_ok, fault, fault_cause}, '0);

        // R10: write in the same cycle as request
        write_mask(64'h0);
        req_valid = 1'b1; pte_word = make_pte(5, 64'h0); base_perm = 3'b111; key_check_en = 1'b1;
        mask_we = 1'b1; mask_wdata = 64'h1 << (62 - 10);
        @(negedge clk);
        mask_we = 1'b0; req_valid = 1'b0;
        check("R10 old mask used", {resp_valid, perm_out, exec_ok, fault, fault_cause},
              expect_of(5, 3'b111, 1'b1, 64'h0));
        shadow = 64'h1 << (62 - 10);
        probe("R10 new mask applies next", 5, 3'b111, 1'b1, 64'h0);
        // R7: fault tracks exec_ok over all base vectors
        for (int b = 0; b < 8; b++) probe("R7 fault vs exec_ok", 5, 3'(b), 1'b1, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule